// File: doc/BRIEF.md
# Bit-Serial Arithmetic and Logic Unit

This block computes one 32-bit arithmetic or logic result a bit at a time. Each operand arrives as a serial stream, least-significant bit first, one bit from each stream per clock. A single full adder with a registered carry does all the arithmetic. The block gets add, increment, subtract and decrement by conditioning the second operand and choosing the carry that enters on the first bit. The bitwise AND, OR, XOR and NOT functions share the same output selector.

A controller raises `start_i` in the same cycle as bit 0 of the operands. At that edge the block captures the operation code, gated by `op_valid_i`, and holds it for the whole word. The result bit for each position appears combinationally on `res_bit_o` in the same cycle as its operand bits. In the cycle after the last bit, `done_o` pulses and `carry_o` takes the word's final carry flag. `carry_o` keeps that value until the next word completes.

Top module: `serial_alu`

## Requirements
- R1: A word takes exactly 32 active cycles. The `start_i` cycle carries bit 0 and the next 31 cycles carry bits 1 to 31. `res_bit_o` in each active cycle is the result bit for that cycle's operand bits.
- R2: Code 4'b0000 with `op_valid_i` high gives A+B. `carry_o` is the carry out of bit 31.
- R3: Code 4'b0001 gives A+1, with B ignored. `carry_o` is the adder carry out, so it is 1 only for A=0xFFFFFFFF.
- R4: Code 4'b0010 gives A-B in two's complement. `carry_o` is 1 exactly when a borrow occurs, that is when A<B unsigned.
- R5: Code 4'b0011 gives A-1, with B ignored. `carry_o` is the adder carry out without inversion, so it is 1 unless A=0.
- R6: Codes 4'b0100, 4'b0101, 4'b0110 and 4'b0111 give A AND B, A OR B, A XOR B and NOT A. For all four, `carry_o` is 0.
- R7: When `op_valid_i` is low, or code bit 3 is set, the block performs add whatever the code is.
- R8: The operation is sampled only in the `start_i` cycle. Changes to `op_code_i` or `op_valid_i` during the rest of the word have no effect.
- R9: `done_o` is a one-cycle pulse in the cycle after bit 31. `carry_o` takes the new flag in that same cycle.
- R10: After reset, `done_o` and `carry_o` are 0. `carry_o` holds its value between completions. `res_bit_o` is 0 in every cycle that is not active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Marks bit 0 of a new word and samples the operation |
| op_valid_i | input | 1 | Qualifies `op_code_i`; when low, the block adds |
| op_code_i | input | 4 | Operation select |
| a_bit_i | input | 1 | Serial operand A, LSB first |
| b_bit_i | input | 1 | Serial operand B, LSB first |
| res_bit_o | output | 1 | Serial result bit for the current position |
| done_o | output | 1 | One-cycle pulse after the last bit |
| carry_o | output | 1 | Final carry or borrow flag of the last completed word |

## Verification
The assertions assume that `start_i` is never raised while a word is in progress. They also assume that reset is held low across at least one clock edge before the first word. The bench respects both conditions: each word ends with a full idle cycle before the next `start_i`, and the bench releases reset only after several edges. During every non-start cycle of a word, the stimulus deliberately drives an inverted code and an inverted valid. This keeps operation capture under test without leaving the single-start assumption.

// File: rtl/serial_alu_pkg.sv
package serial_alu_pkg;

    localparam int CODE_W = 4;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_INC = 3'd1,
        OP_SUB = 3'd2,
        OP_DEC = 3'd3,
        OP_AND = 3'd4,
        OP_OR  = 3'd5,
        OP_XOR = 3'd6,
        OP_NOT = 3'd7
    } alu_op_e;

    // An invalid or upper-half code falls back to addition
    function automatic alu_op_e decode_op(input logic valid, input logic [CODE_W-1:0] code);
        if (!valid || code[CODE_W-1]) begin
            return OP_ADD;
        end
        return alu_op_e'(code[2:0]);
    endfunction

endpackage

// File: rtl/serial_alu_operand.sv
module serial_alu_operand
    import serial_alu_pkg::*;
(
    input  alu_op_e op,
    input  logic    b_bit,
    output logic    b_eff,
    output logic    cin_preset
);
    logic zero_b;
    logic flip_b;

    always_comb begin
        zero_b     = (op == OP_INC) || (op == OP_DEC);
        flip_b     = (op == OP_SUB) || (op == OP_DEC);
        cin_preset = (op == OP_INC) || (op == OP_SUB);
        b_eff      = (zero_b ? 1'b0 : b_bit) ^ flip_b;
    end
endmodule

// File: rtl/serial_alu_fa.sv
module serial_alu_fa (
    input  logic a,
    input  logic b,
    input  logic cin,
    output logic sum,
    output logic cout
);
    always_comb begin
        sum  = a ^ b ^ cin;
        cout = (a & b) | (cin & (a ^ b));
    end
endmodule

// File: rtl/serial_alu_outmux.sv
module serial_alu_outmux
    import serial_alu_pkg::*;
(
    input  alu_op_e op,
    input  logic    a,
    input  logic    b,
    input  logic    sum,
    input  logic    cout,
    output logic    res,
    output logic    flag
);
    always_comb begin
        case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_NOT:  res = ~a;
            default: res = sum;
        endcase

        case (op)
            OP_SUB:                         flag = ~cout;
            OP_AND, OP_OR, OP_XOR, OP_NOT:  flag = 1'b0;
            default:                        flag = cout;
        endcase
    end
endmodule

// File: rtl/serial_alu.sv
module serial_alu
    import serial_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              op_valid_i,
    input  logic [CODE_W-1:0] op_code_i,
    input  logic              a_bit_i,
    input  logic              b_bit_i,
    output logic              res_bit_o,
    output logic              done_o,
    output logic              carry_o
);
    localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WIDTH - 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        alu_op_e          op;
        logic             carry;
        logic             done;
        logic             flag;
    } state_t;

    state_t  state_d, state_q;
    alu_op_e cur_op;
    logic    active;
    logic    last_bit;
    logic    b_eff;
    logic    cin_preset;
    logic    cin;
    logic    sum;
    logic    cout;
    logic    mux_res;
    logic    word_flag;

    always_comb begin
        cur_op   = start_i ? decode_op(op_valid_i, op_code_i) : state_q.op;
        active   = start_i | state_q.busy;
        last_bit = start_i ? (WIDTH == 1) : (state_q.cnt == LAST_IDX);
    end

    serial_alu_operand u_operand (
        .op         (cur_op),
        .b_bit      (b_bit_i),
        .b_eff      (b_eff),
        .cin_preset (cin_preset)
    );

    // The first bit ignores the stored carry
    assign cin = start_i ? cin_preset : state_q.carry;

    serial_alu_fa u_fa (
        .a    (a_bit_i),
        .b    (b_eff),
        .cin  (cin),
        .sum  (sum),
        .cout (cout)
    );

    serial_alu_outmux u_outmux (
        .op   (cur_op),
        .a    (a_bit_i),
        .b    (b_bit_i),
        .sum  (sum),
        .cout (cout),
        .res  (mux_res),
        .flag (word_flag)
    );

    always_comb begin
        state_d      = state_q;
        state_d.done = 1'b0;
        if (active) begin
            state_d.carry = cout;
            state_d.op    = cur_op;
            if (last_bit) begin
                state_d.busy = 1'b0;
                state_d.done = 1'b1;
                state_d.flag = word_flag;
            end else begin
                state_d.busy = 1'b1;
                state_d.cnt  = start_i ? CNT_W'(1) : state_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign res_bit_o = active & mux_res;
    assign done_o    = state_q.done;
    assign carry_o   = state_q.flag;

endmodule

// File: rtl/serial_alu_chk.sv
module serial_alu_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       a_bit_i,
    input logic       res_bit_o,
    input logic       done_o,
    input logic       carry_o,
    input logic       busy,
    input logic [2:0] op
);
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R1
    done_after_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(busy));

    // R10
    carry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(carry_o));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !busy) |-> !res_bit_o);

    // R6
    logic_no_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && op[2]) |-> !carry_o);

    // R6
    not_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !start_i && op == 3'd7) |-> (res_bit_o == !a_bit_i));
endmodule

bind serial_alu serial_alu_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .a_bit_i   (a_bit_i),
    .res_bit_o (res_bit_o),
    .done_o    (done_o),
    .carry_o   (carry_o),
    .busy      (state_q.busy),
    .op        (state_q.op)
);

// File: tb/test_serial_alu.sv
`timescale 1ns/100ps
module test_serial_alu;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       op_valid_i = 1'b0;
    logic [3:0] op_code_i = 4'd0;
    logic       a_bit_i = 1'b0;
    logic       b_bit_i = 1'b0;
    logic       res_bit_o;
    logic       done_o;
    logic       carry_o;

    int  n_chk = 0;
    int  n_bad = 0;
    logic prev_flag = 1'b0;
    logic [31:0] seed = 32'h1234_5678;

    always #2.5 clk = ~clk;

    serial_alu i_serial_alu (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .op_valid_i (op_valid_i),
        .op_code_i  (op_code_i),
        .a_bit_i    (a_bit_i),
        .b_bit_i    (b_bit_i),
        .res_bit_o  (res_bit_o),
        .done_o     (done_o),
        .carry_o    (carry_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model(input logic valid, input logic [3:0] code,
                         input logic [31:0] a, input logic [31:0] b,
                         output logic [31:0] r, output logic c, output string tag);
        logic [2:0]  eff;
        logic [32:0] wide;
        eff = (!valid || code[3]) ? 3'd0 : code[2:0];
        c   = 1'b0;
        case (eff)
            3'd0: begin wide = {1'b0, a} + {1'b0, b}; r = wide[31:0]; c = wide[32]; tag = "R2"; end
            3'd1: begin wide = {1'b0, a} + 33'd1;     r = wide[31:0]; c = wide[32]; tag = "R3"; end
            3'd2: begin r = a - b; c = (a < b); tag = "R4"; end
            3'd3: begin r = a - 32'd1; c = (a != 32'd0); tag = "R5"; end
            3'd4: begin r = a & b; tag = "R6"; end
            3'd5: begin r = a | b; tag = "R6"; end
            3'd6: begin r = a ^ b; tag = "R6"; end
            default: begin r = ~a; tag = "R6"; end
        endcase
        if (eff == 3'd0 && (!valid || code[3])) tag = "R7";
    endtask

    task automatic run_word(input logic valid, input logic [3:0] code,
                            input logic [31:0] a, input logic [31:0] b);
        logic [31:0] got;
        logic [31:0] exp_r;
        logic        exp_c;
        string       tag;
        model(valid, code, a, b, exp_r, exp_c, tag);
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            start_i    = (i == 0);
            // R8: scramble the operation after the start cycle
            op_valid_i = (i == 0) ? valid : ~valid;
            op_code_i  = (i == 0) ? code : ~code;
            a_bit_i    = a[i];
            b_bit_i    = b[i];
            #1;
            got[i] = res_bit_o;
            if (i == 16) check("R10 carry hold", {31'd0, carry_o}, {31'd0, prev_flag});
            if (i == 1)  check("R9 no early done", {31'd0, done_o}, 32'd0);
        end
        @(negedge clk);
        start_i = 1'b0;
        a_bit_i = 1'b0;
        b_bit_i = 1'b0;
        #1;
        check("R9 done pulse", {31'd0, done_o}, 32'd1);
        check({tag, " R1 R8 result"}, got, exp_r);
        check({tag, " carry"}, {31'd0, carry_o}, {31'd0, exp_c});
        check("R10 idle output", {31'd0, res_bit_o}, 32'd0);
        prev_flag = exp_c;
    endtask

    function automatic logic [31:0] pattern(input int k, inout logic [31:0] s);
        case (k)
            0: return 32'h0000_0000;
            1: return 32'hFFFF_FFFF;
            2: return 32'h0000_0001;
            3: return 32'h8000_0000;
            4: return 32'h7FFF_FFFF;
            5: return 32'hAAAA_5555;
            default: begin
                s = s * 32'd1664525 + 32'd1013904223;
                return s;
            end
        endcase
    endfunction

    initial begin
        #(200000 * 5);
        n_chk++;
        n_bad++;
        $display("FAIL R1 watchdog actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R10 reset done", {31'd0, done_o}, 32'd0);
        check("R10 reset carry", {31'd0, carry_o}, 32'd0);
        check("R10 reset output", {31'd0, res_bit_o}, 32'd0);
        rst_n = 1'b1;
        for (int v = 0; v < 2; v++) begin
            for (int code = 0; code < 16; code++) begin
                for (int k = 0; k < 16; k++) begin
                    logic [31:0] a;
                    logic [31:0] b;
                    a = pattern(k, seed);
                    b = pattern((k * 7 + 3) % 16, seed);
                    run_word(v[0] ? 1'b1 : 1'b0, 4'(code), a, b);
                end
            end
        end
        // Borrow and carry edges
        run_word(1'b1, 4'b0010, 32'd5, 32'd5);
        run_word(1'b1, 4'b0010, 32'd4, 32'd5);
        run_word(1'b1, 4'b0001, 32'hFFFF_FFFF, 32'h1234_0000);
        run_word(1'b1, 4'b0011, 32'd0, 32'hFFFF_FFFF);
        run_word(1'b1, 4'b0100, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule